// File: doc/BRIEF.md
# Ethernet Link and Activity LED Driver

This block drives two status lamps for an Ethernet port. A 16-bit configuration word picks a display mode for each lamp. Single-cycle strobes mark transmit, receive and collision events. Two level inputs report link-up and full duplex. Each lamp can show one activity source, a status level, a status level combined with activity, a fixed level, or one of two blink rates.

Activity strobes last only one clock, so a per-lamp stretch counter can hold an event visible for one of three durations. A 2-bit selector in the configuration word picks the duration. The stretch is applied in one of three ways, depending on the mode:
- Plain activity modes stretch only when the stretch-enable bit is set.
- Combined modes always stretch.
- Status and fixed modes never stretch.

One free-running prescaler feeds every lamp that blinks, so lamps set to the same blink rate stay in phase. The stretch lengths and blink half-periods are parameters counted in clock cycles. Each output is 1 when its lamp is lit.

Top module: `eth_led_driver`

## Requirements
- R1: Configuration fields are placed as follows: lamp A mode in bits 11:8, lamp B mode in bits 7:4, stretch select in bits 3:2, stretch enable in bit 1. Bits 15:12 and bit 0 have no effect on either lamp.
- R2: Outputs are registered, and 1 means lit. Each output reflects the inputs sampled at the previous rising edge. Mode 4'h4 shows link-up, 4'h5 shows full duplex, 4'h8 is always lit and 4'h9 is always dark.
- R3: The reserved mode codes 4'h0, 4'h6 and 4'hF keep the lamp dark.
- R4: Modes 4'h1 (tx), 4'h2 (rx), 4'h3 (collision) and 4'h7 (tx or rx) light the lamp. With stretch enable 0, the lamp is lit only for the one cycle that follows each event cycle.
- R5: With stretch enable 1, an event in the modes of R4 keeps the lamp lit for D cycles. D is set by the stretch select: 2'b00 gives STRETCH_NORM, 2'b01 gives STRETCH_MED, 2'b10 gives STRETCH_LONG, and 2'b11 is treated as 2'b00.
- R6: A qualifying event during a running stretch reloads the stretch to its full length.
- R7: Modes 4'hC (link plus rx) and 4'hD (link plus tx/rx) light the lamp while link is up. The lamp goes dark for D cycles after each qualifying event, whatever the stretch enable. While link is down the lamp stays dark.
- R8: Mode 4'hE lights the lamp for full duplex and leaves it dark for half duplex. The lamp is inverted for D cycles after each collision, whatever the stretch enable.
- R9: Mode 4'hA toggles every BLINK_FAST_HALF cycles and mode 4'hB toggles every BLINK_SLOW_HALF cycles. Two lamps in the same blink mode stay equal every cycle.
- R10: Each lamp has its own stretch counter. An event that qualifies for one lamp does not light the other.
- R11: The reset configuration value is 16'h3422. It makes lamp A show link and lamp B show stretched receive activity with length STRETCH_NORM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Mode, stretch select and stretch enable configuration |
| tx_evt | input | 1 | One-cycle transmit event strobe |
| rx_evt | input | 1 | One-cycle receive event strobe |
| col_evt | input | 1 | One-cycle collision event strobe |
| link_up | input | 1 | Link status level |
| full_dup | input | 1 | Duplex status level (1 = full) |
| led_a | output | 1 | Lamp A drive, 1 = lit |
| led_b | output | 1 | Lamp B drive, 1 = lit |

## Verification
Each lamp passes through one output register. A change of status, mode or fixed level is therefore visible one cycle after the edge that samples it. An activity event sampled at edge k lights the lamp from the cycle after k, for one cycle or for D cycles. The bench drives every input on the falling edge and samples on the following falling edges. Stretch length is measured as the exact run of lit, or for the combined modes dark, samples that starts on the first falling edge after the event. Blink checks measure one complete high run between two observed transitions, so the prescaler phase at reset does not matter.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

    typedef enum logic [3:0] {
        LM_RSV0       = 4'h0,
        LM_TX         = 4'h1,
        LM_RX         = 4'h2,
        LM_COL        = 4'h3,
        LM_LINK       = 4'h4,
        LM_DUPLEX     = 4'h5,
        LM_RSV6       = 4'h6,
        LM_TXRX       = 4'h7,
        LM_ON         = 4'h8,
        LM_OFF        = 4'h9,
        LM_BLINK_FAST = 4'hA,
        LM_BLINK_SLOW = 4'hB,
        LM_LINK_RX    = 4'hC,
        LM_LINK_TXRX  = 4'hD,
        LM_DUP_COL    = 4'hE,
        LM_RSV15      = 4'hF
    } led_mode_e;

    typedef enum logic [1:0] {
        SS_NORM = 2'b00,
        SS_MED  = 2'b01,
        SS_LONG = 2'b10,
        SS_RSV  = 2'b11
    } stretch_sel_e;

    typedef enum logic [1:0] {
        SP_NONE     = 2'd0,
        SP_OPTIONAL = 2'd1,
        SP_ALWAYS   = 2'd2
    } stretch_policy_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic col;
    } led_evt_t;

    typedef struct packed {
        logic link;
        logic full_dup;
    } led_status_t;

    localparam logic [15:0] LED_CFG_RESET = 16'h3422;
    localparam int NUM_LAMPS = 2;

    function automatic stretch_policy_e mode_policy(led_mode_e m);
        case (m)
            LM_TX, LM_RX, LM_COL, LM_TXRX:          return SP_OPTIONAL;
            LM_LINK_RX, LM_LINK_TXRX, LM_DUP_COL:   return SP_ALWAYS;
            default:                                return SP_NONE;
        endcase
    endfunction

    function automatic logic mode_event(led_mode_e m, led_evt_t e);
        case (m)
            LM_TX:                  return e.tx;
            LM_RX, LM_LINK_RX:      return e.rx;
            LM_COL, LM_DUP_COL:     return e.col;
            LM_TXRX, LM_LINK_TXRX:  return e.tx | e.rx;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic mode_reserved(led_mode_e m);
        return (m == LM_RSV0) || (m == LM_RSV6) || (m == LM_RSV15);
    endfunction

endpackage

// File: rtl/eth_led_toggle.sv
module eth_led_toggle #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic phase_o
);
    localparam int W = (HALF > 1) ? $clog2(HALF + 1) : 1;
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt_q;
    logic         ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_o = ph_q;

    a_r9_phase_steady: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> $stable(ph_q))
        else $error("R9 blink phase moved before half period elapsed");

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST)
        else $error("R9 blink prescaler out of range");
endmodule

// File: rtl/eth_led_blink.sv
module eth_led_blink #(
    parameter int FAST_HALF = 4,
    parameter int SLOW_HALF = 10
) (
    input  logic clk,
    input  logic rst,
    output logic fast_o,
    output logic slow_o
);
    eth_led_toggle #(.HALF(FAST_HALF)) u_fast (
        .clk(clk), .rst(rst), .phase_o(fast_o)
    );
    eth_led_toggle #(.HALF(SLOW_HALF)) u_slow (
        .clk(clk), .rst(rst), .phase_o(slow_o)
    );
endmodule

// File: rtl/eth_led_stretch.sv
module eth_led_stretch
    import eth_led_pkg::*;
#(
    parameter int DUR_NORM = 5,
    parameter int DUR_MED  = 9,
    parameter int DUR_LONG = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig_i,
    input  logic         use_i,
    input  stretch_sel_e sel_i,
    output logic         active_o
);
    localparam int MAX_NM = (DUR_NORM > DUR_MED) ? DUR_NORM : DUR_MED;
    localparam int MAXD   = (MAX_NM > DUR_LONG) ? MAX_NM : DUR_LONG;
    localparam int W      = $clog2(MAXD + 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] dur;

    always_comb begin
        case (sel_i)
            SS_MED:  dur = W'(DUR_MED);
            SS_LONG: dur = W'(DUR_LONG);
            default: dur = W'(DUR_NORM);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!use_i)
            cnt_q <= '0;
        else if (trig_i)
            cnt_q <= dur - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = trig_i | (cnt_q != '0);

    a_r5_hold_running: assert property (@(posedge clk) disable iff (rst)
        (use_i && !trig_i && cnt_q > W'(1) && $stable(use_i)) |=> active_o)
        else $error("R5 stretch ended early");

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < W'(MAXD))
        else $error("R6 stretch counter beyond longest duration");
endmodule

// File: rtl/eth_led_lane.sv
module eth_led_lane
    import eth_led_pkg::*;
#(
    parameter int DUR_NORM = 5,
    parameter int DUR_MED  = 9,
    parameter int DUR_LONG = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  led_mode_e    mode_i,
    input  stretch_sel_e sel_i,
    input  logic         en_i,
    input  led_evt_t     evt_i,
    input  led_status_t  stat_i,
    input  logic         fast_i,
    input  logic         slow_i,
    output logic         led_o
);
    stretch_policy_e policy;
    logic            trig;
    logic            use_st;
    logic            act;
    logic            led_d;
    logic            led_q;

    assign policy = mode_policy(mode_i);
    assign trig   = mode_event(mode_i, evt_i);
    assign use_st = (policy == SP_ALWAYS) || ((policy == SP_OPTIONAL) && en_i);

    eth_led_stretch #(
        .DUR_NORM(DUR_NORM), .DUR_MED(DUR_MED), .DUR_LONG(DUR_LONG)
    ) u_stretch (
        .clk(clk), .rst(rst), .trig_i(trig), .use_i(use_st),
        .sel_i(sel_i), .active_o(act)
    );

    always_comb begin
        case (mode_i)
            LM_TX, LM_RX, LM_COL, LM_TXRX: led_d = act;
            LM_LINK:                       led_d = stat_i.link;
            LM_DUPLEX:                     led_d = stat_i.full_dup;
            LM_ON:                         led_d = 1'b1;
            LM_OFF:                        led_d = 1'b0;
            LM_BLINK_FAST:                 led_d = fast_i;
            LM_BLINK_SLOW:                 led_d = slow_i;
            LM_LINK_RX, LM_LINK_TXRX:      led_d = stat_i.link & ~act;
            LM_DUP_COL:                    led_d = stat_i.full_dup ^ act;
            default:                       led_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) led_q <= 1'b0;
        else     led_q <= led_d;
    end

    assign led_o = led_q;

    a_r3_reserved_dark: assert property (@(posedge clk) disable iff (rst)
        mode_reserved(mode_i) |=> !led_o)
        else $error("R3 reserved mode lit the lamp");

    a_r2_fixed_on: assert property (@(posedge clk) disable iff (rst)
        (mode_i == LM_ON) |=> led_o)
        else $error("R2 on mode dark");

    a_r2_fixed_off: assert property (@(posedge clk) disable iff (rst)
        (mode_i == LM_OFF) |=> !led_o)
        else $error("R2 off mode lit");

    a_r2_link_follow: assert property (@(posedge clk) disable iff (rst)
        (mode_i == LM_LINK) |=> (led_o == $past(stat_i.link)))
        else $error("R2 link mode does not follow link");

    a_r4_event_lights: assert property (@(posedge clk) disable iff (rst)
        (policy == SP_OPTIONAL && trig) |=> led_o)
        else $error("R4 activity event did not light lamp");

    a_r7_link_down_dark: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == LM_LINK_RX || mode_i == LM_LINK_TXRX) && !stat_i.link) |=> !led_o)
        else $error("R7 combined mode lit with link down");
endmodule

// File: rtl/eth_led_driver.sv
module eth_led_driver
    import eth_led_pkg::*;
#(
    parameter int STRETCH_NORM    = 4_000_000,
    parameter int STRETCH_MED     = 7_000_000,
    parameter int STRETCH_LONG    = 14_000_000,
    parameter int BLINK_FAST_HALF = 2_500_000,
    parameter int BLINK_SLOW_HALF = 10_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cfg_word,
    input  logic        tx_evt,
    input  logic        rx_evt,
    input  logic        col_evt,
    input  logic        link_up,
    input  logic        full_dup,
    output logic        led_a,
    output logic        led_b
);
    led_mode_e    modes [NUM_LAMPS];
    stretch_sel_e sel;
    logic         en;
    led_evt_t     evt;
    led_status_t  stat;
    logic         fast_ph;
    logic         slow_ph;
    logic [NUM_LAMPS-1:0] led_vec;
    logic         unused_cfg_bits;

    assign modes[0] = led_mode_e'(cfg_word[11:8]);
    assign modes[1] = led_mode_e'(cfg_word[7:4]);
    assign sel      = stretch_sel_e'(cfg_word[3:2]);
    assign en       = cfg_word[1];
    assign unused_cfg_bits = ^{cfg_word[15:12], cfg_word[0]};

    assign evt  = '{tx: tx_evt, rx: rx_evt, col: col_evt};
    assign stat = '{link: link_up, full_dup: full_dup};

    eth_led_blink #(
        .FAST_HALF(BLINK_FAST_HALF), .SLOW_HALF(BLINK_SLOW_HALF)
    ) u_blink (
        .clk(clk), .rst(rst), .fast_o(fast_ph), .slow_o(slow_ph)
    );

    for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lane
        eth_led_lane #(
            .DUR_NORM(STRETCH_NORM), .DUR_MED(STRETCH_MED), .DUR_LONG(STRETCH_LONG)
        ) u_lane (
            .clk(clk), .rst(rst), .mode_i(modes[i]), .sel_i(sel), .en_i(en),
            .evt_i(evt), .stat_i(stat), .fast_i(fast_ph), .slow_i(slow_ph),
            .led_o(led_vec[i])
        );
    end

    assign led_a = led_vec[0];
    assign led_b = led_vec[1];

    a_r9_blink_in_phase: assert property (@(posedge clk) disable iff (rst)
        ((cfg_word[11:8] == cfg_word[7:4]) &&
         (cfg_word[11:8] == LM_BLINK_FAST || cfg_word[11:8] == LM_BLINK_SLOW)) |=> (led_a == led_b))
        else $error("R9 blinking lamps out of phase");
endmodule

// File: tb/eth_led_driver_tb.sv
module eth_led_driver_tb_top;
    localparam int DN = 5, DM = 9, DL = 13, FH = 4, SH = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_word = 16'h0000;
    logic        tx_evt = 1'b0, rx_evt = 1'b0, col_evt = 1'b0;
    logic        link_up = 1'b0, full_dup = 1'b0;
    logic        led_a, led_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    eth_led_driver #(
        .STRETCH_NORM(DN), .STRETCH_MED(DM), .STRETCH_LONG(DL),
        .BLINK_FAST_HALF(FH), .BLINK_SLOW_HALF(SH)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .col_evt(col_evt), .link_up(link_up),
        .full_dup(full_dup), .led_a(led_a), .led_b(led_b)
    );

    // {cfg, link, dup, expected A, expected B}
    localparam logic [19:0] VEC [12] = '{
        {16'h0450, 4'b1010},   // R2 link / duplex
        {16'h0450, 4'b0101},   // R2
        {16'h0890, 4'b1110},   // R2 on / off
        {16'h0980, 4'b0001},   // R2
        {16'h0060, 4'b1100},   // R3 reserved 0 and 6
        {16'h0F00, 4'b1100},   // R3 reserved F
        {16'h06F0, 4'b1000},   // R3
        {16'hF481, 4'b0001},   // R1 reserved bits ignored
        {16'h0CE0, 4'b1111},   // R7 R8 static levels
        {16'h0CE0, 4'b0000},   // R7 R8
        {16'h0170, 4'b1100},   // R4 idle activity modes dark
        {16'h0E40, 4'b1001}    // R8 half duplex dark
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] c);
        @(negedge clk);
        cfg_word = c;
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        tx_evt = (which == 0); rx_evt = (which == 1); col_evt = (which == 2);
        @(negedge clk);
        tx_evt = 1'b0; rx_evt = 1'b0; col_evt = 1'b0;
    endtask

    task automatic run_len(input bit lamp_b, input logic lvl, output int n);
        n = 0;
        while (((lamp_b ? led_b : led_a) === lvl) && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic blink_run(input bit lamp_b, output int n);
        int guard = 0;
        while ((lamp_b ? led_b : led_a) !== 1'b1 && guard < 100) begin guard++; @(negedge clk); end
        while ((lamp_b ? led_b : led_a) !== 1'b0 && guard < 200) begin guard++; @(negedge clk); end
        while ((lamp_b ? led_b : led_a) !== 1'b1 && guard < 300) begin guard++; @(negedge clk); end
        run_len(lamp_b, 1'b1, n);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int n;
        int mism;
        repeat (3) @(negedge clk);
        check("R2 reset A dark", led_a, 1'b0);
        check("R2 reset B dark", led_b, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cfg_word = VEC[i][19:4];
            link_up  = VEC[i][3];
            full_dup = VEC[i][2];
            @(negedge clk);
            check($sformatf("R1/R2/R3 vec%0d A", i), led_a, VEC[i][1]);
            check($sformatf("R1/R2/R3 vec%0d B", i), led_b, VEC[i][0]);
        end
        link_up = 1'b0; full_dup = 1'b0;

        // R11 reset configuration
        link_up = 1'b1;
        set_cfg(16'h3422);
        check("R11 A shows link", led_a, 1'b1);
        pulse(1); run_len(1'b1, 1'b1, n);
        check_int("R11 B rx stretch", n, DN);
        link_up = 1'b0;

        // R4 no stretch
        set_cfg(16'h0020);
        pulse(1); run_len(1'b1, 1'b1, n);
        check_int("R4 rx unstretched", n, 1);
        set_cfg(16'h0070);
        pulse(0); run_len(1'b1, 1'b1, n);
        check_int("R4 txrx tx unstretched", n, 1);
        set_cfg(16'h0030);
        pulse(2); run_len(1'b1, 1'b1, n);
        check_int("R4 col unstretched", n, 1);

        // R5 durations per select
        set_cfg(16'h0022); pulse(1); run_len(1'b1, 1'b1, n);
        check_int("R5 sel00", n, DN);
        set_cfg(16'h0026); pulse(1); run_len(1'b1, 1'b1, n);
        check_int("R5 sel01", n, DM);
        set_cfg(16'h002A); pulse(1); run_len(1'b1, 1'b1, n);
        check_int("R5 sel10", n, DL);
        set_cfg(16'h002E); pulse(1); run_len(1'b1, 1'b1, n);
        check_int("R5 sel11 as normal", n, DN);
        set_cfg(16'h0032); pulse(2); run_len(1'b1, 1'b1, n);
        check_int("R5 col stretched", n, DN);

        // R6 retrigger
        set_cfg(16'h0022);
        pulse(1);
        repeat (2) @(negedge clk);
        pulse(1); run_len(1'b1, 1'b1, n);
        check_int("R6 restart full length", n, DN);

        // R10 independent lamps
        set_cfg(16'h0126);
        pulse(0);
        check("R10 B untouched by tx", led_b, 1'b0);
        run_len(1'b0, 1'b1, n);
        check_int("R10 A tx stretch", n, DM);

        // R7 combined link modes, stretch enable clear
        link_up = 1'b1;
        set_cfg(16'h0C00);
        check("R7 lit with link", led_a, 1'b1);
        pulse(1); run_len(1'b0, 1'b0, n);
        check_int("R7 rx blanks always stretched", n, DN);
        set_cfg(16'h0D04);
        pulse(0); run_len(1'b0, 1'b0, n);
        check_int("R7 tx blanks sel01", n, DM);
        link_up = 1'b0;
        repeat (2) @(negedge clk);
        pulse(1);
        check("R7 dark when link down", led_a, 1'b0);

        // R8 duplex plus collision
        full_dup = 1'b1;
        set_cfg(16'h00E0);
        check("R8 full duplex lit", led_b, 1'b1);
        pulse(2); run_len(1'b1, 1'b0, n);
        check_int("R8 collision inverts full", n, DN);
        full_dup = 1'b0;
        repeat (3) @(negedge clk);
        pulse(2); run_len(1'b1, 1'b1, n);
        check_int("R8 collision inverts half", n, DN);

        // R9 blink
        set_cfg(16'h0AA0);
        mism = 0;
        for (int k = 0; k < 4 * SH; k++) begin
            @(negedge clk);
            if (led_a !== led_b) mism++;
        end
        check_int("R9 fast lamps in phase", mism, 0);
        blink_run(1'b0, n);
        check_int("R9 fast half period", n, FH);
        set_cfg(16'h0BB0);
        mism = 0;
        for (int k = 0; k < 4 * SH; k++) begin
            @(negedge clk);
            if (led_a !== led_b) mism++;
        end
        check_int("R9 slow lamps in phase", mism, 0);
        blink_run(1'b1, n);
        check_int("R9 slow half period", n, SH);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule